// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block runs one complete NAND flash operation from a descriptor that the host loads through a small register write port. A single write to the start register begins the operation. The sequencer then performs these steps in order:

- one command latch cycle;
- up to a parameterised number of address latch cycles;
- an optional second command byte;
- a fixed wait before the ready/busy line may be trusted;
- a wait for the device to become ready;
- a data phase that moves a programmed number of bytes between the flash I/O bus and a local page buffer.

Two-phase flash operations, such as a large-page read with a confirm byte, run as one pass with no host action between the phases.

Completion sets a sticky interrupt bit. The host clears that bit by writing a one to it. Every strobe has the same shape: a fixed number of clocks low, framed by a setup clock before it and hold clocks after it. During the whole cycle the latch enables, the chip enable and the driven data stay unchanged. The page buffer sits outside the block. The block reads it combinationally and writes it with a one-clock write enable.

Top module: `nand_cmd_seq`

## Requirements
- R1: During and right after reset, both chip enables are high, both strobes are high, CLE, ALE and the I/O output enable are low, and the interrupt output is low.
- R2: A write to register 0 with bit 31 set starts an operation. Bits 7:0 go out first as a command cycle (CLE high). Bit 19 picks the chip enable: 0 drives ce_n[0] low, 1 drives ce_n[1] low.
- R3: If bit 30 of register 0 is set, the sequencer issues (bits 29:27)+1 address cycles, capped at MAX_ADDR_CYC, with ALE high. The bytes go out in this order: reg 3 bits 7:0, reg 3 bits 15:8, then reg 4 bits 7:0, 15:8 and 23:16.
- R4: If bit 8 of register 1 is set, one more command cycle carrying register 1 bits 7:0 follows the address cycles. If bit 8 is clear, no such cycle is issued.
- R5: A first command of 0x70 or 0x90 with bit 30 clear still gets exactly one address cycle, carrying reg 3 bits 7:0.
- R6: Register 2 holds the data byte count N. With bit 26 set, N RE# cycles capture bytes into buffer addresses 0..N-1, and nothing above N-1 is written. With only bit 25 set, N WE# cycles send buffer bytes 0..N-1 with CLE and ALE low. If N is 0, or neither bit is set, there are no data cycles.
- R7: After the last command or address cycle, no data strobe occurs and the interrupt does not rise until at least T_WB clocks have passed and R/B# has been seen high.
- R8: Completion sets the interrupt. A write to register 5 with bit 31 set clears it. A write to register 5 with bit 31 clear leaves it unchanged.
- R9: dev_ready follows nf_rb_n through two flip-flops: it changes on the second rising edge after R/B# changes.
- R10: Every WE# or RE# low pulse lasts exactly T_STROBE clocks. CLE, ALE and the driven byte do not change while a strobe is low.
- R11: A start write made while an operation is still running is ignored. It adds no bus cycles, either during that operation or after it.
- R12: At most one chip enable is low at any time, and both are high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 start/control, 1 second command, 2 byte count, 3 low address, 4 high address, 5 interrupt) |
| reg_wdata | input | 32 | Register write data |
| irq | output | 1 | Sticky completion flag |
| dev_ready | output | 1 | Synchronised ready/busy level |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_ce_n | output | 2 | Chip enables, active low |
| nf_rb_n | input | 1 | Ready/busy from the device, low when busy |
| nf_io_i | input | 8 | I/O bus input |
| nf_io_o | output | 8 | I/O bus output |
| nf_io_oe | output | 1 | I/O bus output enable |
| pb_addr | output | DLEN_W | Page buffer byte address |
| pb_wdata | output | 8 | Page buffer write data |
| pb_we | output | 1 | Page buffer write enable |
| pb_rdata | input | 8 | Page buffer read data |

## Verification
The bench builds the block with these values:

| Parameter | Value |
|---|---|
| T_STROBE | 2 |
| T_HOLD | 1 |
| T_WB | 4 |
| MAX_ADDR_CYC | 5 |
| DLEN_W | 8 |

The short strobe and wait intervals let several dozen full operations fit in a short run, including random busy stretches on R/B#. With five address cycles allowed, the 3-bit count field can ask for more than five, so the cap is exercised. An 8-bit count gives a 256-byte buffer, which leaves room to check that a read never writes past its last byte.

// File: rtl/nand_seq_pkg.sv
// Package: shared types and register layout for the NAND command sequencer.
// Assumes: register indices and control bit positions are fixed by the host software.
package nand_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD1, S_ADDR, S_CMD2, S_TWB, S_RDY, S_DATA, S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_IDLE, PH_SETUP, PH_LOW, PH_HOLD
    } bus_phase_t;

    localparam logic [2:0] RG_CTRL  = 3'd0;
    localparam logic [2:0] RG_CMD2  = 3'd1;
    localparam logic [2:0] RG_COUNT = 3'd2;
    localparam logic [2:0] RG_ADRLO = 3'd3;
    localparam logic [2:0] RG_ADRHI = 3'd4;
    localparam logic [2:0] RG_IRQ   = 3'd5;

    localparam int B_GO      = 31;
    localparam int B_ADR_EN  = 30;
    localparam int B_ADR_LSB = 27;
    localparam int B_RD      = 26;
    localparam int B_WR      = 25;
    localparam int B_CSEL    = 19;
    localparam int B_CMD2_V  = 8;

    localparam logic [7:0] OP_STATUS = 8'h70;
    localparam logic [7:0] OP_IDENT  = 8'h90;

endpackage

// File: rtl/nand_rb_sync.sv
// Module: two-flop synchroniser for the device ready/busy line.
// Assumes: the line is asynchronous to clk; reset reports busy.
module nand_rb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_n,
    output logic ready
);
    logic meta;

    // Purpose: shift the raw line through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta  <= 1'b0;
            ready <= 1'b0;
        end else begin
            meta  <= rb_n;
            ready <= meta;
        end
    end
endmodule

// File: rtl/nand_addr_pick.sv
// Module: selects the byte sent on address cycle idx from the two address words.
// Assumes: the low word gives cycles 0 and 1; the high word gives one byte per later cycle.
module nand_addr_pick #(
    parameter int MAX_ADDR_CYC = 5,
    parameter int AI_W         = 3,
    localparam int A2_W        = 8 * (MAX_ADDR_CYC - 2)
) (
    input  logic [15:0]     adr_lo,
    input  logic [A2_W-1:0] adr_hi,
    input  logic [AI_W-1:0] idx,
    output logic [7:0]      byte_o
);
    logic [7:0] lane [MAX_ADDR_CYC];

    // Purpose: lay every address cycle's byte out as one lane.
    for (genvar g = 0; g < MAX_ADDR_CYC; g++) begin : g_lane
        if (g < 2) begin : g_lo
            assign lane[g] = adr_lo[8*g +: 8];
        end else begin : g_hi
            assign lane[g] = adr_hi[8*(g-2) +: 8];
        end
    end

    // Purpose: pick the lane for the current cycle; out of range gives zero.
    always_comb begin
        byte_o = 8'h00;
        for (int k = 0; k < MAX_ADDR_CYC; k++) begin
            if (idx == AI_W'(k)) byte_o = lane[k];
        end
    end
endmodule

// File: rtl/nand_bus_cycle.sv
// Module: times one flash bus cycle: a setup clock, T_STROBE clocks with the strobe low,
// then T_HOLD clocks with the strobe high.
// Assumes: the caller holds CLE/ALE/data steady from start until done; T_STROBE, T_HOLD >= 1.
module nand_bus_cycle
    import nand_seq_pkg::*;
#(
    parameter int T_STROBE = 3,
    parameter int T_HOLD   = 2,
    localparam int CNT_MAX = (T_STROBE > T_HOLD) ? T_STROBE : T_HOLD,
    localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_read,
    output logic idle,
    output logic we_n,
    output logic re_n,
    output logic cap_en,
    output logic done
);
    bus_phase_t       phase;
    logic [CNT_W-1:0] cnt;
    logic             rd_q;

    // Purpose: advance the phase of the current bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            rd_q  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_SETUP;
                    rd_q  <= is_read;
                end
                PH_SETUP: begin
                    phase <= PH_LOW;
                    cnt   <= '0;
                end
                PH_LOW: if (cnt == CNT_W'(T_STROBE - 1)) begin
                    phase <= PH_HOLD;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: if (cnt == CNT_W'(T_HOLD - 1)) begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    // Purpose: decode strobes and event pulses from the phase.
    always_comb begin
        idle   = (phase == PH_IDLE);
        we_n   = !((phase == PH_LOW) && !rd_q);
        re_n   = !((phase == PH_LOW) && rd_q);
        cap_en = (phase == PH_LOW) && rd_q && (cnt == CNT_W'(T_STROBE - 1));
        done   = (phase == PH_HOLD) && (cnt == CNT_W'(T_HOLD - 1));
    end

    // R10: the two strobes are never low together
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    // R10: a cycle that starts leaves idle on the next clock
    a_r10_start_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start) |=> !idle);
endmodule

// File: rtl/nand_cmd_seq.sv
// Module: NAND flash command sequencer top. It runs command, address, second command,
// a tWB wait, a ready wait and a data phase from one host descriptor.
// Assumes: the host loads registers 1..4 before the start write and leaves them alone
// until the interrupt; the page buffer read is combinational.
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int T_STROBE     = 3,
    parameter int T_HOLD       = 2,
    parameter int T_WB         = 6,
    parameter int MAX_ADDR_CYC = 5,
    parameter int DLEN_W       = 12,
    localparam int AI_W        = $clog2(MAX_ADDR_CYC + 1),
    localparam int A2_W        = 8 * (MAX_ADDR_CYC - 2),
    localparam int TW_W        = $clog2(T_WB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              irq,
    output logic              dev_ready,
    output logic              nf_cle,
    output logic              nf_ale,
    output logic              nf_we_n,
    output logic              nf_re_n,
    output logic [1:0]        nf_ce_n,
    input  logic              nf_rb_n,
    input  logic [7:0]        nf_io_i,
    output logic [7:0]        nf_io_o,
    output logic              nf_io_oe,
    output logic [DLEN_W-1:0] pb_addr,
    output logic [7:0]        pb_wdata,
    output logic              pb_we,
    input  logic [7:0]        pb_rdata
);
    seq_state_t        state, state_d;
    logic [8:0]        cmd2_r;
    logic [DLEN_W-1:0] count_r;
    logic [15:0]       adr_lo_r;
    logic [A2_W-1:0]   adr_hi_r;
    logic [7:0]        cmd1_q;
    logic              rd_q, wr_q, csel_q;
    logic [AI_W-1:0]   naddr_q, aidx;
    logic [DLEN_W-1:0] dcnt;
    logic [TW_W-1:0]   twb_cnt;
    logic              go_wr, has_data, bus_state;
    logic              eng_idle, eng_start, eng_read, eng_cap, eng_done;
    logic [7:0]        adr_byte;
    logic [3:0]        n_raw;
    logic [AI_W-1:0]   n_pick;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign go_wr    = reg_we && (reg_addr == RG_CTRL) && reg_wdata[B_GO];
    assign has_data = (rd_q || wr_q) && (count_r != '0);

    // Purpose: work out the address cycle count from a start write.
    always_comb begin
        n_raw = {1'b0, reg_wdata[B_ADR_LSB +: 3]} + 4'd1;
        if (reg_wdata[B_ADR_EN]) begin
            n_pick = (n_raw > 4'(MAX_ADDR_CYC)) ? AI_W'(MAX_ADDR_CYC) : AI_W'(n_raw);
        end else if (reg_wdata[7:0] == OP_STATUS || reg_wdata[7:0] == OP_IDENT) begin
            n_pick = AI_W'(1);
        end else begin
            n_pick = '0;
        end
    end

    // Purpose: store descriptor registers written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd2_r   <= '0;
            count_r  <= '0;
            adr_lo_r <= '0;
            adr_hi_r <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RG_CMD2:  cmd2_r   <= reg_wdata[8:0];
                RG_COUNT: count_r  <= reg_wdata[DLEN_W-1:0];
                RG_ADRLO: adr_lo_r <= reg_wdata[15:0];
                RG_ADRHI: adr_hi_r <= reg_wdata[A2_W-1:0];
                default: ;
            endcase
        end
    end

    // Purpose: latch the start word, but only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd1_q  <= '0;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
            csel_q  <= 1'b0;
            naddr_q <= '0;
        end else if (go_wr && state == S_IDLE) begin
            cmd1_q  <= reg_wdata[7:0];
            rd_q    <= reg_wdata[B_RD];
            wr_q    <= reg_wdata[B_WR] && !reg_wdata[B_RD];
            csel_q  <= reg_wdata[B_CSEL];
            naddr_q <= n_pick;
        end
    end

    // Purpose: choose the next sequencer state.
    always_comb begin
        state_d = state;
        case (state)
            S_IDLE: if (go_wr) state_d = S_CMD1;
            S_CMD1: if (eng_done)
                state_d = (naddr_q != '0) ? S_ADDR : (cmd2_r[B_CMD2_V] ? S_CMD2 : S_TWB);
            S_ADDR: if (eng_done && aidx == naddr_q - AI_W'(1))
                state_d = cmd2_r[B_CMD2_V] ? S_CMD2 : S_TWB;
            S_CMD2: if (eng_done) state_d = S_TWB;
            S_TWB:  if (twb_cnt == TW_W'(T_WB - 1)) state_d = S_RDY;
            S_RDY:  if (dev_ready) state_d = has_data ? S_DATA : S_DONE;
            S_DATA: if (eng_done && dcnt == count_r - 1'b1) state_d = S_DONE;
            default: state_d = S_IDLE;
        endcase
    end

    // Purpose: state register plus the address, data and wait counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            aidx    <= '0;
            dcnt    <= '0;
            twb_cnt <= '0;
        end else begin
            state <= state_d;
            if (state == S_IDLE) begin
                aidx <= '0;
                dcnt <= '0;
            end
            if (state == S_ADDR && eng_done) aidx <= aidx + 1'b1;
            if (state == S_DATA && eng_done) dcnt <= dcnt + 1'b1;
            twb_cnt <= (state == S_TWB) ? twb_cnt + 1'b1 : '0;
        end
    end

    // Purpose: sticky completion flag, cleared by writing one to bit 31.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else if (state == S_DONE) irq <= 1'b1;
        else if (reg_we && reg_addr == RG_IRQ && reg_wdata[31]) irq <= 1'b0;
    end

    assign bus_state = (state == S_CMD1) || (state == S_ADDR) ||
                       (state == S_CMD2) || (state == S_DATA);
    assign eng_start = bus_state && eng_idle;
    assign eng_read  = (state == S_DATA) && rd_q;

    nand_bus_cycle #(.T_STROBE(T_STROBE), .T_HOLD(T_HOLD)) u_cyc (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .is_read(eng_read),
        .idle(eng_idle), .we_n(nf_we_n), .re_n(nf_re_n),
        .cap_en(eng_cap), .done(eng_done)
    );

    nand_addr_pick #(.MAX_ADDR_CYC(MAX_ADDR_CYC), .AI_W(AI_W)) u_pick (
        .adr_lo(adr_lo_r), .adr_hi(adr_hi_r), .idx(aidx), .byte_o(adr_byte)
    );

    nand_rb_sync u_rb (.clk(clk), .rst_n(rst_n), .rb_n(nf_rb_n), .ready(dev_ready));

    // Purpose: drive the flash pins and the page buffer port from the state.
    always_comb begin
        nf_cle   = (state == S_CMD1) || (state == S_CMD2);
        nf_ale   = (state == S_ADDR);
        nf_io_oe = (state == S_CMD1) || (state == S_ADDR) || (state == S_CMD2) ||
                   (state == S_DATA && wr_q);
        case (state)
            S_CMD1:  nf_io_o = cmd1_q;
            S_ADDR:  nf_io_o = adr_byte;
            S_CMD2:  nf_io_o = cmd2_r[7:0];
            S_DATA:  nf_io_o = wr_q ? pb_rdata : 8'h00;
            default: nf_io_o = 8'h00;
        endcase
        nf_ce_n = 2'b11;
        if (state != S_IDLE && state != S_DONE) nf_ce_n[csel_q] = 1'b0;
        pb_addr  = dcnt;
        pb_wdata = nf_io_i;
        pb_we    = eng_cap && (state == S_DATA);
    end

    logic past_ok;
    // Purpose: mark that at least one clock has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else past_ok <= 1'b1;
    end

    // R12: at most one chip enable low
    a_r12_one_ce: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~nf_ce_n));
    // R12: both chip enables high while idle
    a_r12_idle_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (nf_ce_n == 2'b11));
    // R2: CLE and ALE never high together
    a_r2_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));
    // R10: pins stay put while a strobe stays low
    a_r10_pins_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !nf_we_n && $past(!nf_we_n)) |->
        ($stable(nf_cle) && $stable(nf_ale) && $stable(nf_io_o)));
    // R7: leaving the ready wait only with R/B# seen high
    a_r7_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RDY && state_d != S_RDY) |-> dev_ready);
    // R8: the flag rises only from completion
    a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(irq)) |-> $past(state == S_DONE));
    // R3: address index stays within the programmed count
    a_r3_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR) |-> (aidx < naddr_q));
    // R6: no data phase with a zero count
    a_r6_no_empty_data: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA) |-> (count_r != '0));
    // R11: a start write while busy leaves the first command untouched
    a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && go_wr) |=> $stable(cmd1_q));
endmodule

// File: tb/sim_nand_cmd_seq.sv
module sim_nand_cmd_seq;
    localparam int T_STROBE = 2;
    localparam int T_HOLD   = 1;
    localparam int T_WB     = 4;
    localparam int MAXA     = 5;
    localparam int DW       = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic irq, dev_ready, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe, pb_we;
    logic [1:0] nf_ce_n;
    logic nf_rb_n = 1'b1;
    logic [7:0] nf_io_i, nf_io_o, pb_wdata, pb_rdata;
    logic [DW-1:0] pb_addr;

    always #4 clk = ~clk;

    nand_cmd_seq #(.T_STROBE(T_STROBE), .T_HOLD(T_HOLD), .T_WB(T_WB),
                   .MAX_ADDR_CYC(MAXA), .DLEN_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .irq(irq), .dev_ready(dev_ready),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_ce_n(nf_ce_n), .nf_rb_n(nf_rb_n), .nf_io_i(nf_io_i), .nf_io_o(nf_io_o),
        .nf_io_oe(nf_io_oe), .pb_addr(pb_addr), .pb_wdata(pb_wdata), .pb_we(pb_we),
        .pb_rdata(pb_rdata)
    );

    int nchk = 0, nbad = 0;
    bit finished = 0;
    int cyc = 0;
    logic [7:0] pbuf [256];
    logic [7:0] snap [256];
    logic [7:0] lg_val [512];
    logic lg_cle [512];
    logic lg_ale [512];
    int lg_n = 0, rd_idx = 0, ce_err = 0, strobe_err = 0;
    int we_lo = 0, re_lo = 0;
    int t_ca = -1, t_dat = -1, t_irq = -1;
    logic [1:0] exp_ce = 2'b11;

    function automatic logic [7:0] rd_pat(input int i);
        return 8'h3C ^ 8'(i * 7);
    endfunction

    assign nf_io_i  = rd_pat(rd_idx);
    assign pb_rdata = pbuf[pb_addr];

    always @(posedge clk) begin
        cyc++;
        if (pb_we) pbuf[pb_addr] <= pb_wdata;
        if (!nf_we_n) we_lo++;
        else if (we_lo != 0) begin if (we_lo != T_STROBE) strobe_err++; we_lo = 0; end
        if (!nf_re_n) re_lo++;
        else if (re_lo != 0) begin if (re_lo != T_STROBE) strobe_err++; re_lo = 0; end
    end

    always @(posedge nf_we_n) begin
        if (lg_n < 512) begin
            lg_cle[lg_n] = nf_cle; lg_ale[lg_n] = nf_ale; lg_val[lg_n] = nf_io_o;
        end
        lg_n++;
        if (nf_ce_n != exp_ce) ce_err++;
        if (nf_cle || nf_ale) t_ca = cyc;
    end
    always @(posedge nf_re_n) begin
        rd_idx++;
        if (nf_ce_n != exp_ce) ce_err++;
    end
    always @(negedge nf_re_n) if (t_dat < 0) t_dat = cyc;
    always @(negedge nf_we_n) if (!nf_cle && !nf_ale && t_dat < 0) t_dat = cyc;
    always @(posedge irq) t_irq = cyc;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_irq(output bit ok);
        int k = 0;
        ok = 0;
        while (k < 3000 && !ok) begin
            @(negedge clk);
            if (irq) ok = 1;
            k++;
        end
    endtask

    function automatic int exp_naddr(input logic [31:0] c1);
        int n;
        if (c1[30]) begin
            n = int'(c1[29:27]) + 1;
            if (n > MAXA) n = MAXA;
        end else if (c1[7:0] == 8'h70 || c1[7:0] == 8'h90) n = 1;
        else n = 0;
        return n;
    endfunction

    function automatic logic [7:0] adr_byte(input int i, input logic [15:0] a1,
                                             input logic [31:0] a2);
        if (i < 2) return a1[8*i +: 8];
        return a2[8*(i-2) +: 8];
    endfunction

    // Runs one operation and checks R2-R8, R10, R12 against bench-built expectations.
    task automatic run_op(input logic [31:0] c1, input logic [8:0] c2, input logic [15:0] a1,
                          input logic [31:0] a2, input int dl, input int busy);
        bit ok, rd, wr, errs;
        int na, ne, t_rel, t_end;
        logic [7:0] ev [300];
        logic ec [300];
        logic ea [300];
        for (int i = 0; i < 256; i++) begin pbuf[i] = 8'($urandom); snap[i] = pbuf[i]; end
        wr_reg(3'd1, {23'd0, c2});
        wr_reg(3'd2, 32'(dl));
        wr_reg(3'd3, {16'd0, a1});
        wr_reg(3'd4, a2);
        rd = c1[26]; wr = c1[25] && !c1[26];
        na = exp_naddr(c1);
        ne = 0;
        ev[ne] = c1[7:0]; ec[ne] = 1; ea[ne] = 0; ne++;
        for (int i = 0; i < na; i++) begin ev[ne] = adr_byte(i, a1, a2); ec[ne] = 0; ea[ne] = 1; ne++; end
        if (c2[8]) begin ev[ne] = c2[7:0]; ec[ne] = 1; ea[ne] = 0; ne++; end
        if (wr) for (int i = 0; i < dl; i++) begin ev[ne] = snap[i]; ec[ne] = 0; ea[ne] = 0; ne++; end
        lg_n = 0; rd_idx = 0; ce_err = 0; strobe_err = 0;
        t_ca = -1; t_dat = -1; t_irq = -1; t_rel = -1;
        exp_ce = c1[19] ? 2'b01 : 2'b10;
        @(negedge clk);
        if (busy > 0) nf_rb_n = 1'b0;
        wr_reg(3'd0, c1 | 32'h8000_0000);
        if (busy > 0) begin
            repeat (busy) @(negedge clk);
            nf_rb_n = 1'b1; t_rel = cyc;
        end
        wait_irq(ok);
        check(ok, "R8 completion flag", int'(ok), 1);
        check(lg_n == ne, "R2/R3/R4/R5/R6 write-cycle count", lg_n, ne);
        errs = 0;
        for (int i = 0; i < ne && i < lg_n; i++)
            if (lg_val[i] != ev[i] || lg_cle[i] != ec[i] || lg_ale[i] != ea[i]) begin
                if (!errs) check(0, "R2/R3/R4 cycle content", int'(lg_val[i]), int'(ev[i]));
                errs = 1;
            end
        if (!errs) check(1, "R3 cycle content", 0, 0);
        check(rd_idx == (rd ? dl : 0), "R6 read strobe count", rd_idx, rd ? dl : 0);
        if (rd) begin
            errs = 0;
            for (int i = 0; i < dl + 3 && i < 256; i++) begin
                if ((i < dl && pbuf[i] != rd_pat(i)) || (i >= dl && pbuf[i] != snap[i])) errs = 1;
            end
            check(!errs, "R6 read data into buffer", int'(errs), 0);
        end
        check(ce_err == 0, "R12/R2 chip enable during cycles", ce_err, 0);
        check(strobe_err == 0, "R10 strobe width", strobe_err, 0);
        t_end = (t_dat >= 0) ? t_dat : t_irq;
        check(t_end - t_ca >= T_WB && (t_rel < 0 || t_end >= t_rel),
              "R7 wait before data/done", t_end - t_ca, T_WB);
        @(negedge clk);
        check(nf_ce_n == 2'b11, "R12 idle chip enables", int'(nf_ce_n), 3);
        wr_reg(3'd5, 32'h0);
        @(negedge clk);
        check(irq == 1'b1, "R8 write without bit 31 keeps flag", int'(irq), 1);
        wr_reg(3'd5, 32'h8000_0000);
        @(negedge clk);
        check(irq == 1'b0, "R8 clear by writing one", int'(irq), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nbad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        logic [31:0] c1;
        bit ok;
        int n0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(nf_ce_n == 2'b11 && nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_io_oe && !irq,
              "R1 reset outputs", {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_io_oe, irq}, 8'hF0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(nf_ce_n == 2'b11 && !irq, "R1 after reset", int'(nf_ce_n), 3);
        // R9: ready synchroniser latency
        nf_rb_n = 1'b0;
        @(negedge clk);
        check(dev_ready == 1'b1, "R9 one edge later unchanged", int'(dev_ready), 1);
        @(negedge clk);
        check(dev_ready == 1'b0, "R9 two edges later follows", int'(dev_ready), 0);
        nf_rb_n = 1'b1;
        repeat (3) @(negedge clk);
        // R2/R3/R4: large-page read style, 5 address cycles, confirm byte, CE1
        run_op(32'h0 | (1<<30) | (4<<27) | (1<<26) | (1<<19) | 32'h00, 9'h130,
               16'hBEEF, 32'h00C0FFEE, 6, 9);
        // R3: field 7 capped at five cycles; write phase
        run_op((1<<30) | (7<<27) | (1<<25) | 32'h80, 9'h110, 16'h1234, 32'h00ABCDEF, 5, 0);
        // R5: status and ID get one address cycle with bit 30 clear
        run_op((1<<26) | 32'h70, 9'h000, 16'h0055, 32'h0, 1, 0);
        run_op((1<<26) | (1<<19) | 32'h90, 9'h000, 16'h00A1, 32'h0, 4, 3);
        // R6: zero count skips data; no address cycles
        run_op((1<<25) | 32'hFF, 9'h000, 16'h0, 32'h0, 0, 5);
        // R4/R6: erase style, three addresses, second command, no data bits
        run_op((1<<30) | (2<<27) | 32'h60, 9'h1D0, 16'h4321, 32'h00000077, 8, 12);
        // R11: start write while busy is ignored
        @(negedge clk);
        nf_rb_n = 1'b0;
        wr_reg(3'd1, 32'h0);
        wr_reg(3'd2, 32'h0);
        wr_reg(3'd3, 32'h0022);
        lg_n = 0; exp_ce = 2'b10; ce_err = 0;
        wr_reg(3'd0, 32'h8000_0000 | (1<<30) | 32'h85);
        repeat (15) @(negedge clk);
        wr_reg(3'd0, 32'h8000_0000 | 32'hEE);
        repeat (5) @(negedge clk);
        nf_rb_n = 1'b1;
        wait_irq(ok);
        n0 = lg_n;
        check(ok && n0 == 2, "R11 only first operation's cycles", n0, 2);
        repeat (40) @(negedge clk);
        check(lg_n == n0 && nf_ce_n == 2'b11, "R11 no later operation", lg_n, n0);
        wr_reg(3'd5, 32'h8000_0000);
        // random operations
        for (int r = 0; r < 30; r++) begin
            logic [7:0] cmd;
            case ($urandom % 6)
                0: cmd = 8'h00;
                1: cmd = 8'h70;
                2: cmd = 8'h90;
                3: cmd = 8'h80;
                4: cmd = 8'h60;
                default: cmd = 8'($urandom);
            endcase
            c1 = {1'b0, 1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
                  5'd0, 1'($urandom), 11'd0, cmd};
            run_op(c1, {1'($urandom), 8'($urandom)}, 16'($urandom), $urandom,
                   int'($urandom % 25), int'($urandom % 20));
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule